// File: doc/BRIEF.md
# Calibration Trigger and Window Sequencer

This block decides when an offset/gain recalibration of a converter channel takes place and then steers that run. Six kinds of request can start a run: a power-up pulse, three system event pulses (over-temperature, under-voltage, system reset), a periodic timer, and a change of the temperature bin. The temperature bin is derived from incoming temperature readings with hysteresis, and it is also exported as the index of the coefficient set that the rest of the chip should use.

A run moves the input path selector from the normal input to the zero source and then to the gain source. It ends by going back to the normal input. After every path switch the block waits a fixed number of settle cycles and throws away a programmed number of samples. In the zero and gain phases it then opens an accumulation window of a fixed number of samples, tagged with the phase, for an external coefficient engine.

Anti-thrash logic has three parts. Requests that arrive while a run or its cool-down is in progress collapse into a single pending run. A cool-down interval separates the end of one run from the start of the next. A runtime budget aborts a stalled run, raises a timeout flag and returns to the normal path. The output data-valid flag is low from any path switch until the post-switch discard on the normal path is complete.

Top module: `recal_sequencer`

## Requirements

- R1: While reset is asserted and right after it is released, `path_sel_o` = 0 (normal), `win_tag_o` = 0, `busy_o` = 0, `timeout_o` = 0 and `coef_set_o` = 0. `data_valid_o` is 0 and first rises after SETTLE_CYC cycles plus DISCARD_N strobes on the normal path.
- R2: A pulse on `pwrup_req_i`, `overtemp_evt_i`, `undervolt_evt_i` or `sysrst_evt_i` is sampled at clock edge k. If the block is idle with no cool-down left, `path_sel_o` becomes 1 (zero source) after edge k+1 and `busy_o` rises at the same edge.
- R3: The path order within a run is always 1 (zero), then 2 (gain), then 0 (normal). Each switch is followed by SETTLE_CYC cycles in which strobes are ignored, and then by DISCARD_N strobes that are discarded. Path code 3 never appears.
- R4: In the zero and gain phases, after the discard, `win_tag_o` equals the path code (1 or 2) for exactly WINDOW_N strobes. Outside those windows it is 0.
- R5: `data_valid_o` is 0 from any path switch until DISCARD_N strobes have been discarded after settling on the normal path. It is 1 only while the path is normal.
- R6: The bin index b (0..NBINS-1) changes only on a `temp_vld_i` reading, and by at most one step per reading. It rises when temp >= (b+1)*BIN_STEP + BIN_HYST and falls when temp + BIN_HYST < b*BIN_STEP. `coef_set_o` shows b.
- R7: A bin change at edge k acts as a trigger sampled at edge k+1, so the run starts after edge k+2 when the block is idle.
- R8: After PERIOD_CYC idle cycles with no other trigger, the periodic timer requests a run. `busy_o` rises PERIOD_CYC+1 edges after the edge that made the block idle.
- R9: No run starts within COOL_CYC edges of the end of the previous run. A request that is pending at the end of a run starts COOL_CYC+1 edges after the end edge.
- R10: Any number of triggers during a run or cool-down result in exactly one further run. `busy_o` is 1 from the start edge until the edge on which the return to normal completes.
- R11: If a run spends BUDGET_CYC cycles on the zero/gain paths, it aborts. At that edge `path_sel_o` goes to 0 and `timeout_o` rises. Then the normal settle/discard follows. `timeout_o` stays set until the next run starts.
- R12: `run_done_o` pulses for one cycle right after the edge that completes the return to normal, for finished and for aborted runs alike.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrup_req_i | input | 1 | Power-up recalibration request pulse |
| overtemp_evt_i | input | 1 | Over-temperature event pulse |
| undervolt_evt_i | input | 1 | Under-voltage event pulse |
| sysrst_evt_i | input | 1 | System reset event pulse |
| temp_i | input | TW | Temperature reading (unsigned) |
| temp_vld_i | input | 1 | Temperature reading strobe |
| sample_stb_i | input | 1 | One converter sample is present this cycle |
| path_sel_o | output | 2 | Input path: 0 normal, 1 zero, 2 gain |
| win_tag_o | output | 2 | Accumulate this cycle's sample into phase 1/2 when non-zero |
| data_valid_o | output | 1 | Normal-path data may be used |
| busy_o | output | 1 | Calibration run in progress |
| timeout_o | output | 1 | Last run was aborted by the budget |
| run_done_o | output | 1 | One-cycle pulse at end of a run |
| coef_set_o | output | BW | Active temperature bin / coefficient set index |

## Verification

Every output comes straight from a register, so a stimulus sampled at edge k shows at the earliest after edge k. An event trigger reaches `path_sel_o` after edge k+1, and a bin change reaches it after edge k+2. A cool-down-limited start comes COOL_CYC+1 edges after the run end, a periodic start PERIOD_CYC+1 edges after going idle, and a timeout BUDGET_CYC edges after the start. The bench drives inputs on the falling edge and samples on the falling edge. It measures these gaps by counting falling edges between the observed output changes. A cycle-level model, written from the requirements, advances on every rising edge, and all outputs are compared against it at each falling edge.

// File: rtl/recal_pkg.sv
package recal_pkg;

  typedef enum logic [1:0] {
    PATH_NORM = 2'd0,
    PATH_ZERO = 2'd1,
    PATH_GAIN = 2'd2
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DISC   = 2'd2,
    ST_WIN    = 2'd3
  } step_e;

endpackage

// File: rtl/recal_tbin.sv
module recal_tbin #(
  parameter int TW       = 8,
  parameter int NBINS    = 4,
  parameter int BIN_STEP = 64,
  parameter int BIN_HYST = 4,
  localparam int BW      = (NBINS > 1) ? $clog2(NBINS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_i,
  input  logic          temp_vld_i,
  output logic [BW-1:0] bin_o,
  output logic          chg_o
);

  logic [BW-1:0] bin_q, bin_d;
  logic          chg_q, chg_d;
  int            t_val, up_thr, dn_thr;

  always_comb begin
    t_val  = int'(temp_i);
    up_thr = (int'(bin_q) + 1) * BIN_STEP + BIN_HYST;
    dn_thr = int'(bin_q) * BIN_STEP;
    bin_d  = bin_q;
    if (temp_vld_i) begin
      if ((int'(bin_q) < NBINS - 1) && (t_val >= up_thr)) begin
        bin_d = bin_q + 1'b1;
      end else if ((bin_q != '0) && (t_val + BIN_HYST < dn_thr)) begin
        bin_d = bin_q - 1'b1;
      end
    end
    chg_d = (bin_d != bin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      chg_q <= 1'b0;
    end else begin
      bin_q <= bin_d;
      chg_q <= chg_d;
    end
  end

  assign bin_o = bin_q;
  assign chg_o = chg_q;

  // R6: a bin move needs a reading and is a single step
  p_bin_needs_reading_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_q != $past(bin_q)) |-> $past(temp_vld_i));
  p_bin_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_q != $past(bin_q)) |-> ((bin_q == $past(bin_q) + 1'b1) || (bin_q == $past(bin_q) - 1'b1)));
  p_bin_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bin_q) < NBINS);

endmodule

// File: rtl/recal_trig.sv
module recal_trig #(
  parameter int PERIOD_CYC = 600,
  parameter int COOL_CYC   = 40,
  localparam int PW        = $clog2(PERIOD_CYC),
  localparam int CLW       = $clog2(COOL_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic bin_chg_i,
  input  logic idle_i,
  input  logic run_end_i,
  output logic start_o
);

  logic           pend_q, pend_d;
  logic [CLW-1:0] cool_q, cool_d;
  logic [PW-1:0]  per_q, per_d;
  logic           per_fire;

  always_comb begin
    per_fire = idle_i && (per_q == PW'(PERIOD_CYC - 1));
    start_o  = pend_q && idle_i && (cool_q == '0);
    pend_d   = (pend_q && !start_o) || evt_i || bin_chg_i || per_fire;
    if (run_end_i) begin
      cool_d = CLW'(COOL_CYC);
    end else if (cool_q != '0) begin
      cool_d = cool_q - 1'b1;
    end else begin
      cool_d = cool_q;
    end
    per_d = (!idle_i || per_fire) ? '0 : per_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cool_q <= '0;
      per_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cool_q <= cool_d;
      per_q  <= per_d;
    end
  end

  // R10: a request not yet served stays pending
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !start_o) |=> pend_q);
  // R8: the idle timer never passes its period
  p_per_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= PW'(PERIOD_CYC - 1));
  // R9: cool-down restarts only at a run end
  p_cool_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cool_q > $past(cool_q)) |-> $past(run_end_i));

endmodule

// File: rtl/recal_seq.sv
module recal_seq
  import recal_pkg::*;
#(
  parameter int SETTLE_CYC = 6,
  parameter int DISCARD_N  = 2,
  parameter int WINDOW_N   = 4,
  parameter int BUDGET_CYC = 120,
  localparam int MX1       = (SETTLE_CYC > DISCARD_N) ? SETTLE_CYC : DISCARD_N,
  localparam int MXC       = (MX1 > WINDOW_N) ? MX1 : WINDOW_N,
  localparam int CW        = $clog2(MXC + 1),
  localparam int BUW       = $clog2(BUDGET_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stb_i,
  output logic [1:0] path_o,
  output logic [1:0] win_tag_o,
  output logic       dv_o,
  output logic       busy_o,
  output logic       to_o,
  output logic       done_o,
  output logic       idle_o,
  output logic       run_end_o
);

  step_e          step_q, step_d;
  path_e          path_q, path_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BUW-1:0] bud_q, bud_d;
  logic           run_q, run_d;
  logic           to_q, to_d;
  logic           done_q;
  logic           fin, abort;

  always_comb begin
    step_d = step_q;
    path_d = path_q;
    cnt_d  = cnt_q;
    bud_d  = bud_q;
    run_d  = run_q;
    to_d   = to_q;
    fin    = (step_q == ST_DISC) && (path_q == PATH_NORM) && stb_i &&
             (cnt_q == CW'(DISCARD_N - 1));
    abort  = run_q && (path_q != PATH_NORM) && (bud_q == BUW'(BUDGET_CYC - 1));
    if ((path_q != PATH_NORM) && !abort) begin
      bud_d = bud_q + 1'b1;
    end
    if (step_q == ST_IDLE) begin
      if (start_i) begin
        step_d = ST_SETTLE;
        path_d = PATH_ZERO;
        cnt_d  = '0;
        bud_d  = '0;
        run_d  = 1'b1;
        to_d   = 1'b0;
      end
    end else if (abort) begin
      step_d = ST_SETTLE;
      path_d = PATH_NORM;
      cnt_d  = '0;
      to_d   = 1'b1;
    end else begin
      unique case (step_q)
        ST_SETTLE: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            step_d = ST_DISC;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DISC: begin
          if (stb_i) begin
            if (cnt_q == CW'(DISCARD_N - 1)) begin
              cnt_d = '0;
              if (path_q == PATH_NORM) begin
                step_d = ST_IDLE;
                run_d  = 1'b0;
              end else begin
                step_d = ST_WIN;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_WIN: begin
          if (stb_i) begin
            if (cnt_q == CW'(WINDOW_N - 1)) begin
              cnt_d  = '0;
              step_d = ST_SETTLE;
              path_d = (path_q == PATH_ZERO) ? PATH_GAIN : PATH_NORM;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_SETTLE;
      path_q <= PATH_NORM;
      cnt_q  <= '0;
      bud_q  <= '0;
      run_q  <= 1'b0;
      to_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      path_q <= path_d;
      cnt_q  <= cnt_d;
      bud_q  <= bud_d;
      run_q  <= run_d;
      to_q   <= to_d;
      done_q <= fin && run_q;
    end
  end

  assign path_o    = path_q;
  assign win_tag_o = (step_q == ST_WIN) ? path_q : PATH_NORM;
  assign dv_o      = (step_q == ST_IDLE);
  assign busy_o    = run_q;
  assign to_o      = to_q;
  assign done_o    = done_q;
  assign idle_o    = (step_q == ST_IDLE);
  assign run_end_o = fin && run_q;

  // R3: legal path codes and fixed order
  p_path_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    path_q != 2'd3);
  p_zero_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(path_q) == PATH_ZERO && path_q != PATH_ZERO) |-> (path_q inside {PATH_GAIN, PATH_NORM}));
  p_gain_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(path_q) == PATH_GAIN && path_q != PATH_GAIN) |-> (path_q == PATH_NORM));
  // R4: windows only on calibration paths
  p_win_on_cal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_WIN) |-> (path_q != PATH_NORM));
  // R5: no valid data right after a switch or off the normal path
  p_switch_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (path_q != $past(path_q)) |-> !dv_o);
  p_valid_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dv_o |-> (path_q == PATH_NORM));
  // R11: abort lands on the normal path, budget counter bounded
  p_abort_normal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> (path_q == PATH_NORM && step_q == ST_SETTLE));
  p_budget_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bud_q < BUW'(BUDGET_CYC));
  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/recal_sequencer.sv
module recal_sequencer #(
  parameter int TW         = 8,
  parameter int NBINS      = 4,
  parameter int BIN_STEP   = 64,
  parameter int BIN_HYST   = 4,
  parameter int SETTLE_CYC = 6,
  parameter int DISCARD_N  = 2,
  parameter int WINDOW_N   = 4,
  parameter int BUDGET_CYC = 120,
  parameter int COOL_CYC   = 40,
  parameter int PERIOD_CYC = 600,
  localparam int BW        = (NBINS > 1) ? $clog2(NBINS) : 1,
  localparam int GW        = $clog2(COOL_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrup_req_i,
  input  logic          overtemp_evt_i,
  input  logic          undervolt_evt_i,
  input  logic          sysrst_evt_i,
  input  logic [TW-1:0] temp_i,
  input  logic          temp_vld_i,
  input  logic          sample_stb_i,
  output logic [1:0]    path_sel_o,
  output logic [1:0]    win_tag_o,
  output logic          data_valid_o,
  output logic          busy_o,
  output logic          timeout_o,
  output logic          run_done_o,
  output logic [BW-1:0] coef_set_o
);

  logic evt_any, bin_chg, idle, run_end, start;

  assign evt_any = pwrup_req_i | overtemp_evt_i | undervolt_evt_i | sysrst_evt_i;

  generate
    if (NBINS > 1) begin : g_bins
      recal_tbin #(
        .TW(TW), .NBINS(NBINS), .BIN_STEP(BIN_STEP), .BIN_HYST(BIN_HYST)
      ) u_tbin (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .temp_vld_i(temp_vld_i),
        .bin_o(coef_set_o), .chg_o(bin_chg)
      );
    end else begin : g_nobins
      assign coef_set_o = '0;
      assign bin_chg    = 1'b0;
    end
  endgenerate

  recal_trig #(
    .PERIOD_CYC(PERIOD_CYC), .COOL_CYC(COOL_CYC)
  ) u_trig (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_any), .bin_chg_i(bin_chg),
    .idle_i(idle), .run_end_i(run_end), .start_o(start)
  );

  recal_seq #(
    .SETTLE_CYC(SETTLE_CYC), .DISCARD_N(DISCARD_N),
    .WINDOW_N(WINDOW_N), .BUDGET_CYC(BUDGET_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stb_i(sample_stb_i),
    .path_o(path_sel_o), .win_tag_o(win_tag_o), .dv_o(data_valid_o),
    .busy_o(busy_o), .to_o(timeout_o), .done_o(run_done_o),
    .idle_o(idle), .run_end_o(run_end)
  );

  // Checker-only counter: edges since the last run end, saturating
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GW'(COOL_CYC);
    end else if (run_end) begin
      gap_q <= '0;
    end else if (gap_q != GW'(COOL_CYC)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R9: a new run honours the cool-down
  p_cool_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (gap_q == GW'(COOL_CYC)));
  // R2: a run always opens on the zero path
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (path_sel_o == 2'd1));

endmodule

// File: tb/recal_sequencer_bench.sv
module recal_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NBINS  = 4;
  localparam int STEP   = 64;
  localparam int HYST   = 4;
  localparam int SETTLE = 6;
  localparam int DISC   = 2;
  localparam int WIN    = 4;
  localparam int BUDGET = 120;
  localparam int COOL   = 40;
  localparam int PERIOD = 600;

  logic clk = 1'b0;
  logic rst_n;
  logic pwrup, ot, uv, sr, tvld, stb;
  logic [7:0] temp;
  logic [1:0] path, wtag, coef;
  logic dv, busy, tout, done;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  stb_en = 1'b0;
  bit  cmp_en = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  recal_sequencer u_recal_sequencer (
    .clk(clk), .rst_n(rst_n), .pwrup_req_i(pwrup), .overtemp_evt_i(ot),
    .undervolt_evt_i(uv), .sysrst_evt_i(sr), .temp_i(temp), .temp_vld_i(tvld),
    .sample_stb_i(stb), .path_sel_o(path), .win_tag_o(wtag), .data_valid_o(dv),
    .busy_o(busy), .timeout_o(tout), .run_done_o(done), .coef_set_o(coef)
  );

  function automatic int bin_next(int b, int t);
    if (b < NBINS - 1 && t >= (b + 1) * STEP + HYST) return b + 1;
    if (b > 0 && t + HYST < b * STEP) return b - 1;
    return b;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Cycle model built from the requirements
  int m_step, m_path, m_cnt, m_bud, m_bin, m_cool, m_per;
  bit m_run, m_to, m_done, m_pend, m_tchg;

  always @(posedge clk or negedge rst_n) begin : mdl
    bit idle, pfire, start, trig, fin, abort;
    int nb;
    if (!rst_n) begin
      m_step <= 1; m_path <= 0; m_cnt <= 0; m_bud <= 0; m_bin <= 0;
      m_cool <= 0; m_per <= 0; m_run <= 0; m_to <= 0; m_done <= 0;
      m_pend <= 0; m_tchg <= 0;
    end else begin
      idle  = (m_step == 0);
      pfire = idle && (m_per == PERIOD - 1);
      start = m_pend && idle && (m_cool == 0);
      trig  = pwrup || ot || uv || sr || pfire || m_tchg;
      m_pend <= (m_pend && !start) || trig;
      m_per  <= (!idle || pfire) ? 0 : m_per + 1;
      nb = tvld ? bin_next(m_bin, int'(temp)) : m_bin;
      m_bin  <= nb;
      m_tchg <= (nb != m_bin);
      fin   = (m_step == 2) && (m_path == 0) && stb && (m_cnt == DISC - 1);
      abort = m_run && (m_path != 0) && (m_bud == BUDGET - 1);
      m_done <= fin && m_run;
      m_cool <= (fin && m_run) ? COOL : ((m_cool > 0) ? m_cool - 1 : 0);
      if (m_path != 0 && !abort) m_bud <= m_bud + 1;
      if (idle) begin
        if (start) begin
          m_step <= 1; m_path <= 1; m_cnt <= 0; m_bud <= 0; m_run <= 1; m_to <= 0;
        end
      end else if (abort) begin
        m_path <= 0; m_step <= 1; m_cnt <= 0; m_to <= 1;
      end else begin
        case (m_step)
          1: if (m_cnt == SETTLE - 1) begin m_step <= 2; m_cnt <= 0; end
             else m_cnt <= m_cnt + 1;
          2: if (stb) begin
               if (m_cnt == DISC - 1) begin
                 m_cnt <= 0;
                 if (m_path == 0) begin m_step <= 0; m_run <= 0; end
                 else m_step <= 3;
               end else m_cnt <= m_cnt + 1;
             end
          3: if (stb) begin
               if (m_cnt == WIN - 1) begin
                 m_cnt <= 0; m_step <= 1; m_path <= (m_path == 1) ? 2 : 0;
               end else m_cnt <= m_cnt + 1;
             end
          default: ;
        endcase
      end
    end
  end

  // Sample strobe source
  always @(negedge clk) stb <= stb_en && ($urandom % 3 == 0);

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(int'(path) == m_path, "R3 path", int'(path), m_path);
      chk(int'(wtag) == ((m_step == 3) ? m_path : 0), "R4 window tag", int'(wtag), (m_step == 3) ? m_path : 0);
      chk(dv == (m_step == 0), "R5 data_valid", int'(dv), int'(m_step == 0));
      chk(int'(coef) == m_bin, "R6 bin", int'(coef), m_bin);
      chk(busy == m_run, "R10 busy", int'(busy), int'(m_run));
      chk(tout == m_to, "R11 timeout", int'(tout), int'(m_to));
      chk(done == m_done, "R12 done", int'(done), int'(m_done));
    end
  end

  task automatic wait_for(input int which, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!((which == 0 && dv) || (which == 1 && busy) || (which == 2 && done) ||
                 (which == 3 && tout)) && n < 2000);
  endtask

  task automatic read_temp(input int t);
    temp = 8'(t);
    tvld = 1'b1;
    @(negedge clk);
    tvld = 1'b0;
  endtask

  initial begin : main
    int g;
    void'($urandom(32'd7331));
    rst_n = 1'b0; pwrup = 0; ot = 0; uv = 0; sr = 0; tvld = 0; temp = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(path == 2'd0, "R1 path", int'(path), 0);
    chk(wtag == 2'd0, "R1 window", int'(wtag), 0);
    chk(!dv, "R1 data_valid", int'(dv), 0);
    chk(!busy && !tout, "R1 busy/timeout", int'({busy, tout}), 0);
    chk(coef == 2'd0, "R1 bin", int'(coef), 0);
    rst_n = 1'b1; cmp_en = 1'b1; stb_en = 1'b1;
    wait_for(0, g);
    chk(dv && g >= SETTLE + DISC, "R1 valid after reset return", g, SETTLE + DISC);

    // R2 trigger latency
    pwrup = 1'b1; @(negedge clk); pwrup = 1'b0;
    chk(path == 2'd0, "R2 path before start", int'(path), 0);
    @(negedge clk);
    chk(path == 2'd1 && busy, "R2 zero path after start", int'(path), 1);

    // R10 two triggers during the run
    repeat (4) @(negedge clk);
    ot = 1'b1; @(negedge clk); ot = 1'b0;
    repeat (6) @(negedge clk);
    uv = 1'b1; @(negedge clk); uv = 1'b0;
    wait_for(2, g);
    // R9 pending run waits out the cool-down
    wait_for(1, g);
    chk(g == COOL + 1, "R9 cool-down gap", g, COOL + 1);
    wait_for(2, g);
    // R8 periodic, R10 no extra run from collapsed triggers
    wait_for(1, g);
    chk(g > COOL + 1, "R10 single pending run", g, PERIOD + 1);
    chk(g == PERIOD + 1, "R8 periodic start", g, PERIOD + 1);
    wait_for(2, g);

    // R11 budget abort with no samples
    repeat (60) @(negedge clk);
    stb_en = 1'b0;
    sr = 1'b1; @(negedge clk); sr = 1'b0;
    wait_for(1, g);
    wait_for(3, g);
    chk(g == BUDGET, "R11 abort time", g, BUDGET);
    chk(path == 2'd0 && wtag == 2'd0, "R11 back to normal", int'(path), 0);
    chk(!dv, "R5 invalid after abort", int'(dv), 0);
    stb_en = 1'b1;
    wait_for(2, g);
    chk(tout, "R11 flag held after run", int'(tout), 1);

    // R6/R7 temperature bins
    repeat (60) @(negedge clk);
    read_temp(67);
    repeat (3) @(negedge clk);
    chk(coef == 2'd0, "R6 below rising threshold", int'(coef), 0);
    chk(!busy, "R7 no run without bin change", int'(busy), 0);
    read_temp(68);
    chk(coef == 2'd1, "R6 rising threshold", int'(coef), 1);
    @(negedge clk);
    chk(!busy, "R7 start latency", int'(busy), 0);
    @(negedge clk);
    chk(busy && path == 2'd1, "R7 bin change starts run", int'(busy), 1);
    read_temp(60);
    chk(coef == 2'd1, "R6 hysteresis hold", int'(coef), 1);
    read_temp(59);
    chk(coef == 2'd0, "R6 falling threshold", int'(coef), 0);
    read_temp(255);
    chk(coef == 2'd1, "R6 single step up", int'(coef), 1);
    read_temp(255);
    chk(coef == 2'd2, "R6 second step", int'(coef), 2);

    // Random phase
    for (int i = 0; i < 14000; i++) begin
      int nt;
      @(negedge clk);
      pwrup = ($urandom % 900 == 0);
      ot    = ($urandom % 700 == 0);
      uv    = ($urandom % 700 == 0);
      sr    = ($urandom % 900 == 0);
      stb_en = ((i % 3000) < 2700);
      tvld  = ($urandom % 16 == 0);
      if (tvld) begin
        nt = int'(temp) + int'($urandom % 25) - 12;
        if ($urandom % 64 == 0) nt = int'($urandom % 256);
        if (nt < 0) nt = 0;
        if (nt > 255) nt = 255;
        temp = 8'(nt);
      end
    end
    pwrup = 0; ot = 0; uv = 0; sr = 0; tvld = 0;
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule